// File: doc/BRIEF.md
# Vertical Luma Enhancer With Coring

This block sharpens the vertical detail of a separated luma stream. Each clock it takes three co-sited luma samples: the sample on the current line and the samples directly above and below it. The two neighbouring lines come from external line stores. From these it forms a signed vertical high-pass term. A programmable dead-zone suppresses small detail, which is mostly noise. The surviving detail is scaled by one of two gains, one for detail that brightens the picture and one for detail that darkens it. The scaled detail is added back to the current-line sample, and the sum is clamped to the pixel range.

Two conditions bypass the enhancer and pass the current-line sample through unchanged. The first is an active-high disable input. The second is a sync flag that the surrounding logic asserts during horizontal and vertical sync intervals. The enhanced path and the bypass path have the same fixed latency of nine clocks. Toggling the disable therefore never shifts the picture, and a change of the disable shows at the output nine clocks after it is sampled. All three settings are sampled together with the pixels, so a setting change also takes effect exactly nine clocks later.

Top module: `luma_vert_enhancer`

## Requirements
- R1: The detail term is D = 2·C − A − B, where C is the current line, A the line above and B the line below. Its magnitude is |D| shifted right by two (truncated toward zero), and its sign is the sign of D. When D is zero the output equals C.
- R2: Coring: if the magnitude is at or below `core_thr` (0..15), the detail becomes zero and the output equals C. Otherwise `core_thr` is subtracted from the magnitude.
- R3: For positive D the output is C + ((cored magnitude · `gain_white`) >> 4), with `gain_white` in the range 0..15.
- R4: For negative D the output is C − ((cored magnitude · `gain_black`) >> 4), with `gain_black` in the range 0..15.
- R5: The result saturates: sums above 255 give 255 and differences below 0 give 0.
- R6: While `enh_off` is 1, the output equals C unchanged. Enhancement applies when `enh_off` is 0.
- R7: While `sync_flag` is 1, the output equals C unchanged, whatever the settings are.
- R8: Every path has a latency of 9 clocks. Inputs sampled at rising edge n, including `enh_off`, `sync_flag` and the settings, determine `luma_out` after rising edge n+8.
- R9: While `rst_n` is low, `luma_out` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_above | input | 8 | Luma sample from the line above |
| line_centre | input | 8 | Luma sample from the current line |
| line_below | input | 8 | Luma sample from the line below |
| core_thr | input | 4 | Coring dead-zone threshold |
| gain_white | input | 4 | Gain in sixteenths for brightening detail |
| gain_black | input | 4 | Gain in sixteenths for darkening detail |
| enh_off | input | 1 | 1 = bypass, 0 = enhance |
| sync_flag | input | 1 | 1 = sync interval, no emphasis |
| luma_out | output | 8 | Enhanced luma |

## Verification
Each sample moves through the stages as a self-contained word that carries its own bypass flag and settings. A fault in one stage therefore corrupts exactly the output sample that leaves the pipeline nine clocks after the faulty input was sampled, and no neighbouring sample. A swapped sign or a swapped gain shows as brightening where darkening is expected. A wrong threshold compare shows as a one-step error at the edges of the dead-zone. A broken bypass shows as a changed value on a sync or disabled sample. A stage too many or too few shifts every comparison by one clock, so the whole stream fails at once.

// File: rtl/vle_pkg.sv
package vle_pkg;
   localparam int VLE_PIX_W  = 8;
   localparam int VLE_CTRL_W = 4;
   localparam int VLE_LAT    = 9;
   localparam int VLE_CORE_STAGES = 5;

   typedef enum logic [0:0] {
      DIR_UP   = 1'b0,
      DIR_DOWN = 1'b1
   } det_dir_t;
endpackage

// File: rtl/vle_delay.sv
module vle_delay #(
   parameter int W     = 8,
   parameter int DEPTH = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] din,
   output logic [W-1:0] dout
);
   generate
      if (DEPTH == 0) begin : g_wire
         assign dout = din;
      end else begin : g_regs
         logic [W-1:0] stage_q [DEPTH];
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int i = 0; i < DEPTH; i++) stage_q[i] <= '0;
            end else begin
               stage_q[0] <= din;
               for (int i = 1; i < DEPTH; i++) stage_q[i] <= stage_q[i-1];
            end
         end
         assign dout = stage_q[DEPTH-1];
      end
   endgenerate
endmodule

// File: rtl/vle_detail.sv
module vle_detail
   import vle_pkg::*;
#(
   parameter int PIX_W  = 8,
   parameter int CTRL_W = 4,
   localparam int SUM_W = PIX_W + 2,
   localparam int MAG_W = PIX_W - 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [PIX_W-1:0]  above,
   input  logic [PIX_W-1:0]  centre,
   input  logic [PIX_W-1:0]  below,
   input  logic [CTRL_W-1:0] core_in,
   input  logic [CTRL_W-1:0] gw_in,
   input  logic [CTRL_W-1:0] gb_in,
   input  logic              keep_in,
   output det_dir_t          dir_o,
   output logic [MAG_W-1:0]  mag_o,
   output logic [PIX_W-1:0]  centre_o,
   output logic [CTRL_W-1:0] core_o,
   output logic [CTRL_W-1:0] gw_o,
   output logic [CTRL_W-1:0] gb_o,
   output logic              keep_o
);
   logic [PIX_W-1:0]  a_q, c_q, b_q;
   logic [CTRL_W-1:0] core_q, gw_q, gb_q;
   logic              keep_q;
   logic [SUM_W-1:0]  twice, pair, diff;
   logic              down;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         a_q <= '0; c_q <= '0; b_q <= '0;
         core_q <= '0; gw_q <= '0; gb_q <= '0; keep_q <= 1'b0;
      end else begin
         a_q <= above; c_q <= centre; b_q <= below;
         core_q <= core_in; gw_q <= gw_in; gb_q <= gb_in; keep_q <= keep_in;
      end
   end

   always_comb begin
      twice = {1'b0, c_q, 1'b0};
      pair  = {2'b00, a_q} + {2'b00, b_q};
      down  = twice < pair;
      diff  = down ? (pair - twice) : (twice - pair);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dir_o <= DIR_UP; mag_o <= '0; centre_o <= '0;
         core_o <= '0; gw_o <= '0; gb_o <= '0; keep_o <= 1'b0;
      end else begin
         dir_o    <= down ? DIR_DOWN : DIR_UP;
         mag_o    <= MAG_W'(diff >> 2);
         centre_o <= c_q;
         core_o   <= core_q;
         gw_o     <= gw_q;
         gb_o     <= gb_q;
         keep_o   <= keep_q;
      end
   end
endmodule

// File: rtl/vle_corer.sv
module vle_corer
   import vle_pkg::*;
#(
   parameter int PIX_W  = 8,
   parameter int CTRL_W = 4,
   localparam int MAG_W = PIX_W - 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  det_dir_t          dir_i,
   input  logic [MAG_W-1:0]  mag_i,
   input  logic [PIX_W-1:0]  centre_i,
   input  logic [CTRL_W-1:0] core_i,
   input  logic [CTRL_W-1:0] gw_i,
   input  logic [CTRL_W-1:0] gb_i,
   input  logic              keep_i,
   output det_dir_t          dir_o,
   output logic [MAG_W-1:0]  mag_o,
   output logic [PIX_W-1:0]  centre_o,
   output logic [CTRL_W-1:0] gain_o,
   output logic              keep_o
);
   logic [MAG_W-1:0] thr;
   logic [MAG_W-1:0] cored;

   always_comb begin
      thr   = MAG_W'(core_i);
      cored = (mag_i <= thr) ? '0 : (mag_i - thr);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dir_o <= DIR_UP; mag_o <= '0; centre_o <= '0; gain_o <= '0; keep_o <= 1'b0;
      end else begin
         dir_o    <= dir_i;
         mag_o    <= cored;
         centre_o <= centre_i;
         gain_o   <= (dir_i == DIR_DOWN) ? gb_i : gw_i;
         keep_o   <= keep_i;
      end
   end
endmodule

// File: rtl/vle_apply.sv
module vle_apply
   import vle_pkg::*;
#(
   parameter int PIX_W  = 8,
   parameter int CTRL_W = 4,
   localparam int MAG_W  = PIX_W - 1,
   localparam int PROD_W = MAG_W + CTRL_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  det_dir_t          dir_i,
   input  logic [MAG_W-1:0]  mag_i,
   input  logic [PIX_W-1:0]  centre_i,
   input  logic [CTRL_W-1:0] gain_i,
   input  logic              keep_i,
   output logic [PIX_W-1:0]  pix_o
);
   logic [PROD_W-1:0] prod;
   logic [MAG_W-1:0]  delta_q;
   det_dir_t          dir_q;
   logic [PIX_W-1:0]  centre_q;
   logic              keep_q;
   logic [PIX_W:0]    up_sum, delta_ext;
   logic [PIX_W-1:0]  result;

   assign prod = PROD_W'(mag_i) * PROD_W'(gain_i);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         delta_q <= '0; dir_q <= DIR_UP; centre_q <= '0; keep_q <= 1'b0;
      end else begin
         delta_q  <= MAG_W'(prod >> CTRL_W);
         dir_q    <= dir_i;
         centre_q <= centre_i;
         keep_q   <= keep_i;
      end
   end

   always_comb begin
      delta_ext = (PIX_W+1)'(delta_q);
      up_sum    = {1'b0, centre_q} + delta_ext;
      if (keep_q)
         result = centre_q;
      else if (dir_q == DIR_UP)
         result = up_sum[PIX_W] ? '1 : up_sum[PIX_W-1:0];
      else if (delta_ext > {1'b0, centre_q})
         result = '0;
      else
         result = centre_q - PIX_W'(delta_q);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pix_o <= '0;
      else        pix_o <= result;
   end
endmodule

// File: rtl/luma_vert_enhancer.sv
module luma_vert_enhancer
   import vle_pkg::*;
#(
   parameter int PIX_W    = VLE_PIX_W,
   parameter int CTRL_W   = VLE_CTRL_W,
   parameter int PIPE_LAT = VLE_LAT,
   localparam int MAG_W   = PIX_W - 1,
   localparam int TAIL    = PIPE_LAT - VLE_CORE_STAGES
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [PIX_W-1:0]  line_above,
   input  logic [PIX_W-1:0]  line_centre,
   input  logic [PIX_W-1:0]  line_below,
   input  logic [CTRL_W-1:0] core_thr,
   input  logic [CTRL_W-1:0] gain_white,
   input  logic [CTRL_W-1:0] gain_black,
   input  logic              enh_off,
   input  logic              sync_flag,
   output logic [PIX_W-1:0]  luma_out
);
   generate
      if (PIPE_LAT < VLE_CORE_STAGES) begin : g_bad_lat
         $error("PIPE_LAT below the arithmetic stage count");
      end
      if (CTRL_W > MAG_W) begin : g_bad_ctrl
         $error("CTRL_W wider than the detail magnitude");
      end
      if (PIX_W < 3) begin : g_bad_pix
         $error("PIX_W too small");
      end
   endgenerate

   det_dir_t          dir2, dir3;
   logic [MAG_W-1:0]  mag2, mag3;
   logic [PIX_W-1:0]  c2, c3, pix5;
   logic [CTRL_W-1:0] core2, gw2, gb2, gain3;
   logic              keep2, keep3;

   vle_detail #(.PIX_W(PIX_W), .CTRL_W(CTRL_W)) u_detail (
      .clk(clk), .rst_n(rst_n),
      .above(line_above), .centre(line_centre), .below(line_below),
      .core_in(core_thr), .gw_in(gain_white), .gb_in(gain_black),
      .keep_in(enh_off | sync_flag),
      .dir_o(dir2), .mag_o(mag2), .centre_o(c2),
      .core_o(core2), .gw_o(gw2), .gb_o(gb2), .keep_o(keep2)
   );

   vle_corer #(.PIX_W(PIX_W), .CTRL_W(CTRL_W)) u_corer (
      .clk(clk), .rst_n(rst_n),
      .dir_i(dir2), .mag_i(mag2), .centre_i(c2),
      .core_i(core2), .gw_i(gw2), .gb_i(gb2), .keep_i(keep2),
      .dir_o(dir3), .mag_o(mag3), .centre_o(c3), .gain_o(gain3), .keep_o(keep3)
   );

   vle_apply #(.PIX_W(PIX_W), .CTRL_W(CTRL_W)) u_apply (
      .clk(clk), .rst_n(rst_n),
      .dir_i(dir3), .mag_i(mag3), .centre_i(c3), .gain_i(gain3), .keep_i(keep3),
      .pix_o(pix5)
   );

   vle_delay #(.W(PIX_W), .DEPTH(TAIL)) u_tail (
      .clk(clk), .rst_n(rst_n), .din(pix5), .dout(luma_out)
   );
endmodule

// File: rtl/vle_checker.sv
module vle_checker #(
   parameter int PIX_W    = 8,
   parameter int CTRL_W   = 4,
   parameter int PIPE_LAT = 9,
   localparam int SUM_W   = PIX_W + 2,
   localparam int FILL_W  = $clog2(PIPE_LAT + 1)
) (
   input logic              clk,
   input logic              rst_n,
   input logic [PIX_W-1:0]  line_above,
   input logic [PIX_W-1:0]  line_centre,
   input logic [PIX_W-1:0]  line_below,
   input logic [CTRL_W-1:0] gain_white,
   input logic [CTRL_W-1:0] gain_black,
   input logic              enh_off,
   input logic              sync_flag,
   input logic [PIX_W-1:0]  luma_out
);
   logic [PIX_W-1:0]    c_hist [PIPE_LAT];
   logic [PIPE_LAT-1:0] off_h, sync_h, pos_h, neg_h, zg_h;
   logic [FILL_W-1:0]   fill;
   logic                full;
   logic [SUM_W-1:0]    twice, pair;

   assign twice = {1'b0, line_centre, 1'b0};
   assign pair  = {2'b00, line_above} + {2'b00, line_below};
   assign full  = (fill == FILL_W'(PIPE_LAT));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < PIPE_LAT; i++) c_hist[i] <= '0;
         off_h <= '0; sync_h <= '0; pos_h <= '0; neg_h <= '0; zg_h <= '0; fill <= '0;
      end else begin
         c_hist[0] <= line_centre;
         for (int i = 1; i < PIPE_LAT; i++) c_hist[i] <= c_hist[i-1];
         off_h  <= {off_h[PIPE_LAT-2:0],  enh_off};
         sync_h <= {sync_h[PIPE_LAT-2:0], sync_flag};
         pos_h  <= {pos_h[PIPE_LAT-2:0],  twice > pair};
         neg_h  <= {neg_h[PIPE_LAT-2:0],  twice < pair};
         zg_h   <= {zg_h[PIPE_LAT-2:0],   (gain_white == '0) && (gain_black == '0)};
         if (!full) fill <= fill + 1'b1;
      end
   end

   a_r6_off_keeps_centre: assert property (@(posedge clk) disable iff (!rst_n)
      (full && off_h[PIPE_LAT-1]) |-> (luma_out == c_hist[PIPE_LAT-1]));

   a_r7_sync_keeps_centre: assert property (@(posedge clk) disable iff (!rst_n)
      (full && sync_h[PIPE_LAT-1]) |-> (luma_out == c_hist[PIPE_LAT-1]));

   a_r3_rise_only_on_positive: assert property (@(posedge clk) disable iff (!rst_n)
      (full && (luma_out > c_hist[PIPE_LAT-1])) |->
         (pos_h[PIPE_LAT-1] && !off_h[PIPE_LAT-1] && !sync_h[PIPE_LAT-1]));

   a_r4_fall_only_on_negative: assert property (@(posedge clk) disable iff (!rst_n)
      (full && (luma_out < c_hist[PIPE_LAT-1])) |->
         (neg_h[PIPE_LAT-1] && !off_h[PIPE_LAT-1] && !sync_h[PIPE_LAT-1]));

   a_r1_flat_keeps_centre: assert property (@(posedge clk) disable iff (!rst_n)
      (full && !pos_h[PIPE_LAT-1] && !neg_h[PIPE_LAT-1]) |-> (luma_out == c_hist[PIPE_LAT-1]));

   a_r2_zero_gains_keep_centre: assert property (@(posedge clk) disable iff (!rst_n)
      (full && zg_h[PIPE_LAT-1]) |-> (luma_out == c_hist[PIPE_LAT-1]));
endmodule

bind luma_vert_enhancer vle_checker #(
   .PIX_W(PIX_W), .CTRL_W(CTRL_W), .PIPE_LAT(PIPE_LAT)
) u_vle_checker (
   .clk(clk), .rst_n(rst_n),
   .line_above(line_above), .line_centre(line_centre), .line_below(line_below),
   .gain_white(gain_white), .gain_black(gain_black),
   .enh_off(enh_off), .sync_flag(sync_flag), .luma_out(luma_out)
);

// File: tb/test_luma_vert_enhancer.sv
module test_luma_vert_enhancer;
   localparam int LAT = 9;
   localparam int MAXV = 8192;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [7:0] line_above = '0, line_centre = '0, line_below = '0;
   logic [3:0] core_thr = '0, gain_white = '0, gain_black = '0;
   logic       enh_off = 1'b0, sync_flag = 1'b0;
   logic [7:0] luma_out;

   always #10 clk = ~clk;

   luma_vert_enhancer i_luma_vert_enhancer (
      .clk(clk), .rst_n(rst_n),
      .line_above(line_above), .line_centre(line_centre), .line_below(line_below),
      .core_thr(core_thr), .gain_white(gain_white), .gain_black(gain_black),
      .enh_off(enh_off), .sync_flag(sync_flag), .luma_out(luma_out)
   );

   int    checks = 0;
   int    failures = 0;
   bit    done = 1'b0;
   int    exp_v [MAXV];
   string tag_v [MAXV];
   int    idx = 0;

   task automatic check(string tag, int act, int expv);
      checks++;
      if (act != expv) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
      end
   endtask

   function automatic int model(int a, int b, int c, int core, int w, int k,
                                bit off, bit sy, output string tag);
      int d, m, r;
      if (off) begin tag = "R6"; return c; end
      if (sy)  begin tag = "R7"; return c; end
      d = 2*c - a - b;
      m = ((d < 0) ? -d : d) >> 2;
      if (d == 0) begin tag = "R1"; return c; end
      if (m <= core) begin tag = "R2"; return c; end
      m = m - core;
      if (d > 0) begin r = c + ((m * w) >> 4); tag = "R3"; end
      else       begin r = c - ((m * k) >> 4); tag = "R4"; end
      if (r > 255) begin r = 255; tag = "R5"; end
      if (r < 0)   begin r = 0;   tag = "R5"; end
      return r;
   endfunction

   // One clock: compare the sample due now (vector idx-LAT), then drive the next.
   task automatic step(int a, int b, int c, int core, int w, int k,
                       bit off, bit sy, string force_tag);
      string t;
      @(negedge clk);
      if (idx >= LAT) check(tag_v[idx-LAT], int'(luma_out), exp_v[idx-LAT]);
      line_above = 8'(a); line_below = 8'(b); line_centre = 8'(c);
      core_thr = 4'(core); gain_white = 4'(w); gain_black = 4'(k);
      enh_off = off; sync_flag = sy;
      exp_v[idx] = model(a, b, c, core, w, k, off, sy, t);
      tag_v[idx] = (force_tag != "") ? force_tag : t;
      idx++;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      check("R9", int'(luma_out), 0);  // R9: reset holds the output at zero
      rst_n = 1'b1;

      for (int core = 0; core < 16; core++) begin
         for (int g = 0; g < 16; g++) begin
            for (int t = 0; t < 24; t++) begin
               int a, b, c;
               if (t == 0)      begin a = 0;   b = 0;   c = 255; end  // R5 top clamp
               else if (t == 1) begin a = 255; b = 255; c = 0;   end  // R5 bottom clamp
               else if (t == 2) begin a = 128; b = 128; c = 128; end  // R1 flat
               else begin
                  a = (t*53 + g*7) % 256;
                  b = (t*91 + core*29) % 256;
                  c = (t*17 + g*3 + core) % 256;
               end
               step(a, b, c, core, g, 15 - g, (t % 7) == 3, (t % 11) == 5, "");
            end
         end
      end

      // R8: disable released mid-stream; the new value must appear exactly LAT clocks later
      for (int i = 0; i < 10; i++) step(0, 0, 100, 0, 15, 15, 1'b1, 1'b0, "R8");
      for (int i = 0; i < 10; i++) step(0, 0, 100, 0, 15, 15, 1'b0, 1'b0, "R8");
      // R7: sync held over strong detail with maximum gains
      for (int i = 0; i < 4; i++)  step(0, 0, 200, 0, 15, 15, 1'b0, 1'b1, "R7");
      for (int i = 0; i < LAT; i++) step(0, 0, 0, 0, 0, 0, 1'b0, 1'b0, "");

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (60000) @(posedge clk);
      if (!done) begin
         failures++;
         $display("FAIL R8 watchdog actual=running expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule